// File: doc/BRIEF.md
# Non-blocking write-through data cache

A small set-associative data cache with one store port and two load ports. A load that hits gets the whole 8-byte line in the same cycle, and both load ports may hit together. A load that misses asks the memory for the line. The memory accepts a read in the same cycle by returning a nonzero transaction tag, and the cache hands that tag to the requester. Some cycles later the memory returns the data with the same tag. The cache then installs the line and passes the data and tag on to the load side in that cycle.

Stores are write-through and allocate on a miss, so every store goes to memory. Only one memory command leaves the cache per cycle. A store wins over load misses, and the miss of load port 0 wins over the miss of load port 1. A load that loses is told to retry. A table of outstanding misses, indexed by memory tag, merges later misses to a block that is already in flight. Replacement uses a saturating age counter per way.

All addresses are line addresses, with the byte offset already removed. The set index is the low `log2(LINES/WAYS)` bits, and the line tag is the bits above it.

Top module: `wt_dcache`

## Requirements
- R1: A load request to a resident line asserts `ld_hit_o` and returns the line on `ld_data_o` in the same cycle, without retry. Both ports can hit in one cycle.
- R2: A load miss that wins the memory port drives `mem_cmd_o`=1 (read) and `mem_addr_o`=line address. If `mem_rtag_i` is nonzero, that tag appears on `ld_tag_o` and no retry is signalled.
- R3: `mem_cmd_o` is 2 (write) whenever a store is requested, 1 (read) for a load miss only when no store is present, and 0 otherwise. Port 0's miss is preferred over port 1's. Any load miss that gets no tag asserts `ld_retry_o`.
- R4: Every store drives a write with its line address and data. The store also updates or allocates the line, so a later load of that address hits with the stored data.
- R5: A read answered with tag 0 is not accepted. The load retries, `ld_tag_o` is 0, and nothing is recorded, so a later miss to the same line issues a fresh read.
- R6: A miss to a line with an outstanding tag gets that tag with no new memory command. If both ports miss on the same new line in one cycle, port 1 receives port 0's tag.
- R7: When `mem_dtag_i` is nonzero, `fill_tag_o` and `fill_data_o` carry the returned tag and data in that cycle. The line is installed and hits from the next cycle on.
- R8: An access to a set clears the accessed way's age and increments the others. A new line fills the lowest-numbered invalid way; otherwise it evicts the way with the largest age, with ties going to the lowest way.
- R9: Age counters saturate at their maximum (15) instead of wrapping.
- R10: Reset invalidates every line and clears every outstanding miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_req_i | input | 1 | Store request |
| st_addr_i | input | LA_W | Store line address |
| st_data_i | input | 8*LINE_B | Store data (full line) |
| ld_req_i | input | 2 | Load request per port |
| ld_addr_i | input | 2 x LA_W | Load line address per port |
| ld_hit_o | output | 2 | Load hit per port |
| ld_data_o | output | 2 x 8*LINE_B | Hit data per port |
| ld_tag_o | output | 2 x MTAG_W | Memory tag given to a missing load, 0 if none |
| ld_retry_o | output | 2 | Load not accepted, keep request asserted |
| mem_cmd_o | output | 2 | 0 idle, 1 read, 2 write |
| mem_addr_o | output | LA_W | Memory line address |
| mem_wdata_o | output | 8*LINE_B | Memory write data |
| mem_rtag_i | input | MTAG_W | Same-cycle read acceptance tag, 0 = rejected |
| mem_dtag_i | input | MTAG_W | Tag of returning data, 0 = none |
| mem_rdata_i | input | 8*LINE_B | Returning line data |
| fill_tag_o | output | MTAG_W | Returned tag passed to the load side |
| fill_data_o | output | 8*LINE_B | Returned data passed to the load side |

## Verification
A vector table drives both load ports with hit/hit, hit/miss, miss/hit and miss/miss address pairs. This separates per-port lookup from cross-port interference. Directed cases then compare a store against two misses, two different misses, two equal misses, and a miss to a line already in flight. Together these tell the priority order apart from tag sharing and tag merging. Fill ordering in one set tells the age-based victim from a fixed way choice. Sixteen hits on one way make a saturating counter and a wrapping counter evict different lines.

// File: rtl/wt_dcache_pkg.sv
package wt_dcache_pkg;
  typedef enum logic [1:0] {
    MEM_IDLE  = 2'd0,
    MEM_READ  = 2'd1,
    MEM_WRITE = 2'd2
  } mem_cmd_e;
endpackage

// File: rtl/dc_victim.sv
module dc_victim #(
  parameter int WAYS  = 2,
  parameter int AGE_W = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][AGE_W-1:0] age_i,
  output logic [WAY_W-1:0]           way_o
);
  logic             found;
  logic [AGE_W-1:0] best;

  always_comb begin
    found = 1'b0;
    way_o = '0;
    best  = age_i[0];
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_i[w] && !found) begin
        found = 1'b1;
        way_o = WAY_W'(w);
      end
    end
    if (!found) begin
      for (int w = 1; w < WAYS; w++) begin
        if (age_i[w] > best) begin
          best  = age_i[w];
          way_o = WAY_W'(w);
        end
      end
    end
  end
endmodule

// File: rtl/dc_miss_table.sv
module dc_miss_table #(
  parameter int MTAG_W = 4,
  parameter int LA_W   = 13,
  localparam int NT    = 1 << MTAG_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       alloc_i,
  input  logic [MTAG_W-1:0]          alloc_tag_i,
  input  logic [LA_W-1:0]            alloc_la_i,
  input  logic [MTAG_W-1:0]          free_tag_i,
  input  logic [1:0][LA_W-1:0]       look_la_i,
  output logic [1:0]                 look_hit_o,
  output logic [1:0][MTAG_W-1:0]     look_tag_o,
  output logic [LA_W-1:0]            fill_la_o
);
  logic [NT-1:0]            valid_q;
  logic [NT-1:0][LA_W-1:0]  la_q;

  assign fill_la_o = la_q[free_tag_i];

  // tag 0 is never a live entry; an entry retiring this cycle does not merge
  always_comb begin
    look_hit_o = '0;
    look_tag_o = '0;
    for (int p = 0; p < 2; p++) begin
      for (int t = 1; t < NT; t++) begin
        if (valid_q[t] && la_q[t] == look_la_i[p] && MTAG_W'(t) != free_tag_i) begin
          look_hit_o[p] = 1'b1;
          look_tag_o[p] = MTAG_W'(t);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      la_q    <= '0;
    end else begin
      if (free_tag_i != '0) valid_q[free_tag_i] <= 1'b0;
      if (alloc_i) begin
        valid_q[alloc_tag_i] <= 1'b1;
        la_q[alloc_tag_i]    <= alloc_la_i;
      end
    end
  end
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
  import wt_dcache_pkg::*;
#(
  parameter int LA_W   = 13,
  parameter int LINE_B = 8,
  parameter int LINES  = 32,
  parameter int WAYS   = 2,
  parameter int AGE_W  = 4,
  parameter int MTAG_W = 4,
  localparam int DATA_W = LINE_B * 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      st_req_i,
  input  logic [LA_W-1:0]           st_addr_i,
  input  logic [DATA_W-1:0]         st_data_i,
  input  logic [1:0]                ld_req_i,
  input  logic [1:0][LA_W-1:0]      ld_addr_i,
  output logic [1:0]                ld_hit_o,
  output logic [1:0][DATA_W-1:0]    ld_data_o,
  output logic [1:0][MTAG_W-1:0]    ld_tag_o,
  output logic [1:0]                ld_retry_o,
  output logic [1:0]                mem_cmd_o,
  output logic [LA_W-1:0]           mem_addr_o,
  output logic [DATA_W-1:0]         mem_wdata_o,
  input  logic [MTAG_W-1:0]         mem_rtag_i,
  input  logic [MTAG_W-1:0]         mem_dtag_i,
  input  logic [DATA_W-1:0]         mem_rdata_i,
  output logic [MTAG_W-1:0]         fill_tag_o,
  output logic [DATA_W-1:0]         fill_data_o
);
  localparam int SETS  = LINES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = LA_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int NLK   = 4; // lookups: load0, load1, store, fill
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic [SETS-1:0][WAYS-1:0]              valid_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag_q;
  logic [SETS-1:0][WAYS-1:0][DATA_W-1:0]  data_q;
  logic [SETS-1:0][WAYS-1:0][AGE_W-1:0]   age_q;
  logic [SETS-1:0][WAYS-1:0]              touch;

  logic [NLK-1:0][LA_W-1:0]  lk_la;
  logic [NLK-1:0][IDX_W-1:0] lk_set;
  logic [NLK-1:0][TAG_W-1:0] lk_tag;
  logic [NLK-1:0]            lk_hit;
  logic [NLK-1:0][WAY_W-1:0] lk_way;
  logic [1:0][WAY_W-1:0]     vic_way;

  logic [1:0]              mt_hit;
  logic [1:0][MTAG_W-1:0]  mt_tag;
  logic [LA_W-1:0]         fill_la;
  logic                    alloc;
  logic [LA_W-1:0]         alloc_la;

  logic [1:0] miss, pend, need;
  logic       gnt0, gnt1, shr1, rok;
  logic [WAY_W-1:0] st_way, fl_way;
  logic       fl_wr;

  assign lk_la[0] = ld_addr_i[0];
  assign lk_la[1] = ld_addr_i[1];
  assign lk_la[2] = st_addr_i;
  assign lk_la[3] = fill_la;

  for (genvar l = 0; l < NLK; l++) begin : g_lookup
    assign lk_set[l] = lk_la[l][IDX_W-1:0];
    assign lk_tag[l] = lk_la[l][LA_W-1:IDX_W];
    always_comb begin
      lk_hit[l] = 1'b0;
      lk_way[l] = '0;
      for (int w = 0; w < WAYS; w++) begin
        if (valid_q[lk_set[l]][w] && tag_q[lk_set[l]][w] == lk_tag[l]) begin
          lk_hit[l] = 1'b1;
          lk_way[l] = WAY_W'(w);
        end
      end
    end
  end

  for (genvar v = 0; v < 2; v++) begin : g_victim
    dc_victim #(.WAYS(WAYS), .AGE_W(AGE_W)) u_vic (
      .valid_i (valid_q[lk_set[2+v]]),
      .age_i   (age_q[lk_set[2+v]]),
      .way_o   (vic_way[v])
    );
  end

  dc_miss_table #(.MTAG_W(MTAG_W), .LA_W(LA_W)) u_mt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (alloc),
    .alloc_tag_i (mem_rtag_i),
    .alloc_la_i  (alloc_la),
    .free_tag_i  (mem_dtag_i),
    .look_la_i   (ld_addr_i),
    .look_hit_o  (mt_hit),
    .look_tag_o  (mt_tag),
    .fill_la_o   (fill_la)
  );

  assign fill_tag_o  = mem_dtag_i;
  assign fill_data_o = mem_rdata_i;

  always_comb begin
    st_way = lk_hit[2] ? lk_way[2] : vic_way[0];
    fl_way = lk_hit[3] ? lk_way[3] : vic_way[1];
    // a store to the same slot in the same cycle carries newer data
    fl_wr  = (mem_dtag_i != '0) &&
             !(st_req_i && lk_set[2] == lk_set[3] && st_way == fl_way);

    for (int p = 0; p < 2; p++) begin
      miss[p] = ld_req_i[p] & ~lk_hit[p];
      pend[p] = miss[p] & mt_hit[p];
      need[p] = miss[p] & ~mt_hit[p];
      ld_hit_o[p]  = ld_req_i[p] & lk_hit[p];
      ld_data_o[p] = ld_hit_o[p] ? data_q[lk_set[p]][lk_way[p]] : '0;
    end
    rok  = mem_rtag_i != '0;
    gnt0 = ~st_req_i & need[0];
    gnt1 = ~st_req_i & ~need[0] & need[1];
    shr1 = ~st_req_i & need[0] & need[1] & (ld_addr_i[0] == ld_addr_i[1]);

    mem_cmd_o   = MEM_IDLE;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    if (st_req_i) begin
      mem_cmd_o   = MEM_WRITE;
      mem_addr_o  = st_addr_i;
      mem_wdata_o = st_data_i;
    end else if (gnt0 || gnt1) begin
      mem_cmd_o  = MEM_READ;
      mem_addr_o = gnt0 ? ld_addr_i[0] : ld_addr_i[1];
    end

    ld_tag_o[0]   = pend[0] ? mt_tag[0] : ((gnt0 & rok) ? mem_rtag_i : '0);
    ld_tag_o[1]   = pend[1] ? mt_tag[1] : (((gnt1 | shr1) & rok) ? mem_rtag_i : '0);
    ld_retry_o[0] = need[0] & ~(gnt0 & rok);
    ld_retry_o[1] = need[1] & ~((gnt1 | shr1) & rok);
    alloc         = (gnt0 | gnt1) & rok;
    alloc_la      = gnt0 ? ld_addr_i[0] : ld_addr_i[1];

    touch = '0;
    for (int p = 0; p < 2; p++)
      if (ld_hit_o[p]) touch[lk_set[p]][lk_way[p]] = 1'b1;
    if (st_req_i) touch[lk_set[2]][st_way] = 1'b1;
    if (fl_wr)    touch[lk_set[3]][fl_way] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      age_q   <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (|touch[s]) begin
          for (int w = 0; w < WAYS; w++) begin
            if (touch[s][w])                age_q[s][w] <= '0;
            else if (age_q[s][w] != AGE_MAX) age_q[s][w] <= age_q[s][w] + 1'b1;
          end
        end
      end
      if (fl_wr)    valid_q[lk_set[3]][fl_way] <= 1'b1;
      if (st_req_i) valid_q[lk_set[2]][st_way] <= 1'b1;
    end
  end

  // array contents need no reset: valid bits gate every use
  always_ff @(posedge clk_i) begin
    if (fl_wr) begin
      tag_q[lk_set[3]][fl_way]  <= lk_tag[3];
      data_q[lk_set[3]][fl_way] <= mem_rdata_i;
    end
    if (st_req_i) begin
      tag_q[lk_set[2]][st_way]  <= lk_tag[2];
      data_q[lk_set[2]][st_way] <= st_data_i;
    end
  end
endmodule

// File: rtl/wt_dcache_chk.sv
module wt_dcache_chk
  import wt_dcache_pkg::*;
#(
  parameter int LA_W   = 13,
  parameter int LINE_B = 8,
  parameter int LINES  = 32,
  parameter int WAYS   = 2,
  parameter int AGE_W  = 4,
  parameter int MTAG_W = 4,
  localparam int DATA_W = LINE_B * 8,
  localparam int SETS   = LINES / WAYS,
  localparam int NT     = 1 << MTAG_W
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              st_req_i,
  input logic [LA_W-1:0]                   st_addr_i,
  input logic [DATA_W-1:0]                 st_data_i,
  input logic [1:0]                        ld_hit_o,
  input logic [1:0][MTAG_W-1:0]            ld_tag_o,
  input logic [1:0]                        ld_retry_o,
  input logic [1:0]                        mem_cmd_o,
  input logic [LA_W-1:0]                   mem_addr_o,
  input logic [DATA_W-1:0]                 mem_wdata_o,
  input logic [MTAG_W-1:0]                 mem_rtag_i,
  input logic [MTAG_W-1:0]                 mem_dtag_i,
  input logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] age_q
);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  // shadow of accepted reads, built from the memory port alone
  logic [NT-1:0]           sv_q;
  logic [NT-1:0][LA_W-1:0] sa_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sv_q <= '0;
      sa_q <= '0;
    end else begin
      if (mem_dtag_i != '0) sv_q[mem_dtag_i] <= 1'b0;
      if (mem_cmd_o == MEM_READ && mem_rtag_i != '0) begin
        sv_q[mem_rtag_i] <= 1'b1;
        sa_q[mem_rtag_i] <= mem_addr_o;
      end
    end
  end

  a_r4_store_write_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_req_i |-> (mem_cmd_o == MEM_WRITE && mem_addr_o == st_addr_i && mem_wdata_o == st_data_i));

  a_r3_read_only_without_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cmd_o == MEM_READ) |-> !st_req_i);

  for (genvar p = 0; p < 2; p++) begin : g_port
    a_r5_retry_carries_no_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_retry_o[p] |-> (ld_tag_o[p] == '0 && !ld_hit_o[p]));
    a_r1_hit_not_retried: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_hit_o[p] |-> !ld_retry_o[p]);
  end

  for (genvar t = 1; t < NT; t++) begin : g_tag
    a_r6_no_duplicate_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_cmd_o == MEM_READ && sv_q[t] && mem_dtag_i != MTAG_W'(t)) |-> (mem_addr_o != sa_q[t]));
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      a_r9_age_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(age_q[s][w]) == AGE_MAX && age_q[s][w] != '0) |-> (age_q[s][w] == AGE_MAX));
    end
  end
endmodule

bind wt_dcache wt_dcache_chk #(
  .LA_W(LA_W), .LINE_B(LINE_B), .LINES(LINES), .WAYS(WAYS), .AGE_W(AGE_W), .MTAG_W(MTAG_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .st_req_i(st_req_i), .st_addr_i(st_addr_i),
  .st_data_i(st_data_i), .ld_hit_o(ld_hit_o), .ld_tag_o(ld_tag_o), .ld_retry_o(ld_retry_o),
  .mem_cmd_o(mem_cmd_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
  .mem_rtag_i(mem_rtag_i), .mem_dtag_i(mem_dtag_i), .age_q(age_q)
);

// File: tb/sim_wt_dcache.sv
module sim_wt_dcache;
  localparam int LA_W = 13;
  localparam int DW   = 64;
  localparam int TW   = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic st_req_i;
  logic [LA_W-1:0] st_addr_i;
  logic [DW-1:0] st_data_i;
  logic [1:0] ld_req_i;
  logic [1:0][LA_W-1:0] ld_addr_i;
  logic [1:0] ld_hit_o, ld_retry_o;
  logic [1:0][DW-1:0] ld_data_o;
  logic [1:0][TW-1:0] ld_tag_o;
  logic [1:0] mem_cmd_o;
  logic [LA_W-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i, fill_data_o;
  logic [TW-1:0] mem_rtag_i, mem_dtag_i, fill_tag_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wt_dcache u0 (
    .clk_i(clk), .rst_ni(rst_ni), .st_req_i(st_req_i), .st_addr_i(st_addr_i),
    .st_data_i(st_data_i), .ld_req_i(ld_req_i), .ld_addr_i(ld_addr_i),
    .ld_hit_o(ld_hit_o), .ld_data_o(ld_data_o), .ld_tag_o(ld_tag_o),
    .ld_retry_o(ld_retry_o), .mem_cmd_o(mem_cmd_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rtag_i(mem_rtag_i), .mem_dtag_i(mem_dtag_i),
    .mem_rdata_i(mem_rdata_i), .fill_tag_o(fill_tag_o), .fill_data_o(fill_data_o)
  );

  function automatic logic [DW-1:0] pat(input logic [LA_W-1:0] a);
    return {19'h5A5A5, a, 19'h01234, a};
  endfunction

  task automatic chk(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic idle();
    st_req_i = 0; st_addr_i = '0; st_data_i = '0;
    ld_req_i = '0; ld_addr_i = '0;
    mem_rtag_i = '0; mem_dtag_i = '0; mem_rdata_i = '0;
  endtask

  task automatic ld(input int p, input logic [LA_W-1:0] a);
    ld_req_i[p] = 1'b1; ld_addr_i[p] = a;
  endtask

  // read issue cycle, then return cycle; the line is resident after the second edge
  task automatic fill_line(input logic [LA_W-1:0] a, input logic [TW-1:0] t);
    @(negedge clk); idle(); ld(0, a); mem_rtag_i = t; #1;
    chk("R2 fill read cmd", DW'(mem_cmd_o), 64'd1);
    @(negedge clk); idle(); mem_dtag_i = t; mem_rdata_i = pat(a); #1;
    chk("R7 fill tag passthrough", DW'(fill_tag_o), DW'(t));
  endtask

  // {addr0, addr1, hit0, hit1}; lines 005, 015, 003 resident
  localparam int NV = 6;
  localparam logic [NV-1:0][2*LA_W+1:0] VEC = {
    {13'h005, 13'h015, 1'b1, 1'b1},
    {13'h003, 13'h005, 1'b1, 1'b1},
    {13'h007, 13'h015, 1'b0, 1'b1},
    {13'h015, 13'h025, 1'b1, 1'b0},
    {13'h103, 13'h013, 1'b0, 1'b0},
    {13'h003, 13'h003, 1'b1, 1'b1}
  };

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R10 / R5: empty after reset, rejected read retries
    @(negedge clk); idle(); ld(0, 13'h005); #1;
    chk("R10 no hit after reset", DW'(ld_hit_o[0]), 64'd0);
    chk("R5 read cmd issued", DW'(mem_cmd_o), 64'd1);
    chk("R5 retry on tag 0", DW'(ld_retry_o[0]), 64'd1);
    chk("R5 tag 0 reported", DW'(ld_tag_o[0]), 64'd0);

    // R2 / R5: fresh read after rejection
    @(negedge clk); idle(); ld(0, 13'h005); mem_rtag_i = 4'd3; #1;
    chk("R2 read cmd", DW'(mem_cmd_o), 64'd1);
    chk("R2 read addr", DW'(mem_addr_o), 64'h005);
    chk("R2 tag given", DW'(ld_tag_o[0]), 64'd3);
    chk("R2 no retry", DW'(ld_retry_o[0]), 64'd0);

    // R6: merge on outstanding miss
    @(negedge clk); idle(); ld(1, 13'h005); mem_rtag_i = 4'd7; #1;
    chk("R6 merged no cmd", DW'(mem_cmd_o), 64'd0);
    chk("R6 merged tag", DW'(ld_tag_o[1]), 64'd3);
    chk("R6 merged no retry", DW'(ld_retry_o[1]), 64'd0);

    // R7: return passes through, then hit
    @(negedge clk); idle(); mem_dtag_i = 4'd3; mem_rdata_i = pat(13'h005); #1;
    chk("R7 fill tag", DW'(fill_tag_o), 64'd3);
    chk("R7 fill data", fill_data_o, pat(13'h005));
    @(negedge clk); idle(); ld(0, 13'h005); #1;
    chk("R7 hit after fill", DW'(ld_hit_o[0]), 64'd1);
    chk("R1 hit data", ld_data_o[0], pat(13'h005));

    fill_line(13'h015, 4'd4);
    fill_line(13'h003, 4'd5);

    // R1: vector walk, reads rejected so misses retry
    for (int i = 0; i < NV; i++) begin
      logic [LA_W-1:0] a0, a1;
      logic h0, h1;
      {a0, a1, h0, h1} = VEC[i];
      @(negedge clk); idle(); ld(0, a0); ld(1, a1); #1;
      chk("R1 vec hit0", DW'(ld_hit_o[0]), DW'(h0));
      chk("R1 vec hit1", DW'(ld_hit_o[1]), DW'(h1));
      if (h0) chk("R1 vec data0", ld_data_o[0], pat(a0));
      if (h1) chk("R1 vec data1", ld_data_o[1], pat(a1));
      chk("R3 vec retry0", DW'(ld_retry_o[0]), DW'(!h0));
      chk("R3 vec retry1", DW'(ld_retry_o[1]), DW'(!h1));
    end

    // R3 / R4: store beats two misses
    @(negedge clk); idle(); st_req_i = 1; st_addr_i = 13'h040; st_data_i = 64'hD1D1_0000_1111_2222;
    ld(0, 13'h100); ld(1, 13'h101); mem_rtag_i = 4'd6; #1;
    chk("R4 write cmd", DW'(mem_cmd_o), 64'd2);
    chk("R4 write addr", DW'(mem_addr_o), 64'h040);
    chk("R4 write data", mem_wdata_o, 64'hD1D1_0000_1111_2222);
    chk("R3 port0 retry under store", DW'(ld_retry_o[0]), 64'd1);
    chk("R3 port1 retry under store", DW'(ld_retry_o[1]), 64'd1);

    // R3: port 0 beats port 1
    @(negedge clk); idle(); ld(0, 13'h100); ld(1, 13'h101); mem_rtag_i = 4'd6; #1;
    chk("R3 read addr port0", DW'(mem_addr_o), 64'h100);
    chk("R3 port0 tag", DW'(ld_tag_o[0]), 64'd6);
    chk("R3 port1 retry", DW'(ld_retry_o[1]), 64'd1);

    // R6: same new line on both ports
    @(negedge clk); idle(); ld(0, 13'h102); ld(1, 13'h102); mem_rtag_i = 4'd7; #1;
    chk("R6 shared addr", DW'(mem_addr_o), 64'h102);
    chk("R6 shared tag0", DW'(ld_tag_o[0]), 64'd7);
    chk("R6 shared tag1", DW'(ld_tag_o[1]), 64'd7);
    chk("R6 shared no retry1", DW'(ld_retry_o[1]), 64'd0);

    // R6 merge on port 1 while port 0 reads
    @(negedge clk); idle(); ld(0, 13'h101); ld(1, 13'h100); mem_rtag_i = 4'd8; #1;
    chk("R6 port0 read addr", DW'(mem_addr_o), 64'h101);
    chk("R6 port1 merged tag", DW'(ld_tag_o[1]), 64'd6);

    // R4: allocate-on-write and store hit
    @(negedge clk); idle(); ld(0, 13'h040); #1;
    chk("R4 alloc hit", DW'(ld_hit_o[0]), 64'd1);
    chk("R4 alloc data", ld_data_o[0], 64'hD1D1_0000_1111_2222);
    @(negedge clk); idle(); st_req_i = 1; st_addr_i = 13'h005; st_data_i = 64'hD2D2_3333_4444_5555; #1;
    @(negedge clk); idle(); ld(1, 13'h005); #1;
    chk("R4 store hit data", ld_data_o[1], 64'hD2D2_3333_4444_5555);

    // R8: victim by age in set 9
    fill_line(13'h009, 4'd9);
    fill_line(13'h019, 4'd10);
    @(negedge clk); idle(); ld(0, 13'h009); #1;
    fill_line(13'h029, 4'd11);
    @(negedge clk); idle(); ld(0, 13'h009); ld(1, 13'h029); #1;
    chk("R8 recent kept", DW'(ld_hit_o[0]), 64'd1);
    chk("R8 new line in", DW'(ld_hit_o[1]), 64'd1);
    @(negedge clk); idle(); ld(0, 13'h019); #1;
    chk("R8 oldest evicted", DW'(ld_hit_o[0]), 64'd0);

    // R9: 16 hits on way 0 make way 1 oldest only if ages saturate
    fill_line(13'h00A, 4'd12);
    fill_line(13'h01A, 4'd13);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); idle(); ld(0, 13'h00A);
    end
    fill_line(13'h02A, 4'd14);
    @(negedge clk); idle(); ld(0, 13'h00A); ld(1, 13'h01A); #1;
    chk("R9 busy way kept", DW'(ld_hit_o[0]), 64'd1);
    chk("R9 saturated way evicted", DW'(ld_hit_o[1]), 64'd0);

    // R10: mid-run reset clears lines and outstanding misses
    @(negedge clk); idle(); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); idle(); ld(0, 13'h005); ld(1, 13'h100); #1;
    chk("R10 line cleared", DW'(ld_hit_o[0]), 64'd0);
    chk("R10 miss table cleared", DW'(ld_tag_o[1]), 64'd0);
    chk("R10 port1 retry", DW'(ld_retry_o[1]), 64'd1);

    @(negedge clk); idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule